// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Styles

This block is a general-purpose I/O controller. It has sixteen pins and a 32-bit word-addressed register port. Software sets each pin as an input or as a driven output and writes the value that output pins drive. It can also read back the current, synchronized level of every pin.

Every line has a 3-bit detection style. Each cycle, the style is applied to the synchronized pin value and to that value from the cycle before. A match sets the line's sticky event bit. Software clears an event bit by writing a 1 to it. The event bits of the low thirteen lines also leave the block as active-high interrupt levels toward a parent interrupt controller. In the level styles, an event bit keeps re-asserting for as long as the pin condition holds, so a clear only sticks once the condition has gone away.

The register port has no handshake. A write lands on the rising edge on which `cfg_wen` is high, and a read returns the word selected by `cfg_addr` combinationally, in the same cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the output-value word (0x00), all style words and all event bits read 0. The direction word (0x04) reads 0xFFFF, so `pin_oe` is 0 and `irq_out` is 0.
- R2: Word 0x00 holds the output values and word 0x04 holds the direction. `pin_out` equals word 0x00. Bit i of `pin_oe` is 1 exactly when bit i of word 0x04 is 0, and 1 in the direction word means input. Both words update on the clock edge of the write.
- R3: Word 0x08 is read-only. Its bit i shows pin i after a two-flop synchronizer, so a pin change is visible after the second rising edge that follows it.
- R4: Word 0x10 holds the styles of lines 0 to 7 and word 0x14 holds those of lines 8 to 15. The style of line i sits in bits [3*(i mod 8)+2 : 3*(i mod 8)], and bits 31:24 of both words read 0.
- R5: Style 0 (level high) sets the event bit on every cycle the synchronized pin is 1. Style 1 (level low) sets it on every cycle the pin is 0. A clear written while the condition holds has no lasting effect.
- R6: Style 2 sets the event bit on a 0-to-1 change of the synchronized pin, style 3 on a 1-to-0 change, and style 4 on either change.
- R7: Style codes 5, 6 and 7 never set an event bit, whatever the pin does.
- R8: Writing word 0x0C clears each event bit whose data bit is 1 and leaves those whose data bit is 0. Reading 0x0C returns the event bits.
- R9: When an event and a clear of the same line fall on one clock edge, the event bit ends up set.
- R10: `irq_out[k]` equals event bit k for lines 0 to 12. Lines 13 to 15 set event bits but drive no interrupt.
- R11: A pin change that matches the line's style sets the event bit, and the matching `irq_out` bit, on the third rising edge after the change.
- R12: Addresses 0x18, 0x1C and every address outside the map read 0, and writes to them change nothing. Bits 31:16 of words 0x00, 0x04, 0x08 and 0x0C read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wen | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Byte address of the register word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| pin_in | input | 16 | Pin levels, asynchronous |
| pin_out | output | 16 | Values driven on output pins |
| pin_oe | output | 16 | Drive enable per pin, 1 = driven |
| irq_out | output | 13 | Active-high interrupt levels for lines 0 to 12 |

## Verification
Register writes are due on the edge that samples `cfg_wen`. Read data is due in the same cycle as the address. The level word follows a pin change two edges later, and event bits and `irq_out` follow it three edges later. The bench drives every input at a falling edge. A behavioural model advances on each rising edge, and all outputs are compared at the next falling edge, so each expected value is taken from the exact cycle in which it is due. The directed checks for pin timing sample the level word after the second edge, and the event word both before and after the third.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W  = 5;
  localparam int STYLE_W = 3;

  localparam logic [ADDR_W-1:0] A_DRIVE  = 5'h00;
  localparam logic [ADDR_W-1:0] A_DIR    = 5'h04;
  localparam logic [ADDR_W-1:0] A_LEVEL  = 5'h08;
  localparam logic [ADDR_W-1:0] A_EVENT  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_STYLE0 = 5'h10;

  typedef enum logic [STYLE_W-1:0] {
    SY_HIGH = 3'd0,
    SY_LOW  = 3'd1,
    SY_RISE = 3'd2,
    SY_FALL = 3'd3,
    SY_ANY  = 3'd4
  } style_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] now_q,
  output logic [W-1:0] last_q
);
  logic [W-1:0] meta_q;

  // two flops for metastability, a third keeps the previous settled value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_q  <= '0;
      last_q <= '0;
    end else begin
      meta_q <= d;
      now_q  <= meta_q;
      last_q <= now_q;
    end
  end
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
  import gpio_irq_pkg::*;
(
  input  logic               cur,
  input  logic               last,
  input  logic [STYLE_W-1:0] style,
  output logic               hit
);
  always_comb begin
    case (style)
      SY_HIGH: hit = cur;
      SY_LOW:  hit = ~cur;
      SY_RISE: hit = cur & ~last;
      SY_FALL: hit = ~cur & last;
      SY_ANY:  hit = cur ^ last;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES  = 16,
  parameter int PER_WORD = 8,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wen,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [N_LINES-1:0]         level,
  input  logic [N_LINES-1:0]         hit,
  output logic [DATA_W-1:0]          rdata,
  output logic [N_LINES-1:0]         drive,
  output logic [N_LINES-1:0]         dir,
  output logic [N_LINES-1:0]         pend,
  output logic [STYLE_W*N_LINES-1:0] style_flat
);
  localparam int NWORD  = N_LINES / PER_WORD;
  localparam int SFLD_W = STYLE_W * PER_WORD;
  localparam logic [DATA_W-1:0] LMASK = DATA_W'({N_LINES{1'b1}});
  localparam logic [DATA_W-1:0] SMASK = DATA_W'({SFLD_W{1'b1}});

  logic [DATA_W-1:0]  drive_q, dir_q;
  logic [DATA_W-1:0]  style_q [NWORD];
  logic [N_LINES-1:0] clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      dir_q   <= LMASK;
    end else if (wen) begin
      if (addr == A_DRIVE) drive_q <= wdata & LMASK;
      if (addr == A_DIR)   dir_q   <= wdata & LMASK;
    end
  end

  for (genvar r = 0; r < NWORD; r++) begin : g_style
    localparam logic [ADDR_W-1:0] AW = A_STYLE0 + ADDR_W'(4 * r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  style_q[r] <= '0;
      else if (wen && addr == AW)  style_q[r] <= wdata & SMASK;
    end
    assign style_flat[r*SFLD_W +: SFLD_W] = style_q[r][SFLD_W-1:0];
  end

  // write-1-to-clear; a detected event on the same edge overrides the clear
  assign clr = (wen && addr == A_EVENT) ? wdata[N_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= hit | (pend & ~clr);
  end

  assign drive = drive_q[N_LINES-1:0];
  assign dir   = dir_q[N_LINES-1:0];

  always_comb begin
    rdata = '0;
    case (addr)
      A_DRIVE: rdata = drive_q;
      A_DIR:   rdata = dir_q;
      A_LEVEL: rdata = DATA_W'(level);
      A_EVENT: rdata = DATA_W'(pend);
      default: rdata = '0;
    endcase
    for (int r = 0; r < NWORD; r++) begin
      if (addr == A_STYLE0 + ADDR_W'(4 * r)) rdata = style_q[r];
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES  = 16,
  parameter int N_IRQ    = 13,
  parameter int PER_WORD = 8,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wen,
  input  logic [4:0]         cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic [N_LINES-1:0] pin_in,
  output logic [N_LINES-1:0] pin_out,
  output logic [N_LINES-1:0] pin_oe,
  output logic [N_IRQ-1:0]   irq_out
);
  logic [N_LINES-1:0]         lvl_now, lvl_last;
  logic [N_LINES-1:0]         hit_vec, pend_vec, dir_vec;
  logic [STYLE_W*N_LINES-1:0] style_flat;

  gpio_sync #(.W(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in),
    .now_q(lvl_now), .last_q(lvl_last)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    gpio_line_detect u_det (
      .cur(lvl_now[i]),
      .last(lvl_last[i]),
      .style(style_flat[i*STYLE_W +: STYLE_W]),
      .hit(hit_vec[i])
    );
  end

  gpio_regs #(.N_LINES(N_LINES), .PER_WORD(PER_WORD), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wen(cfg_wen), .addr(cfg_addr), .wdata(cfg_wdata),
    .level(lvl_now), .hit(hit_vec),
    .rdata(cfg_rdata),
    .drive(pin_out), .dir(dir_vec),
    .pend(pend_vec), .style_flat(style_flat)
  );

  assign pin_oe  = ~dir_vec;
  assign irq_out = pend_vec[N_IRQ-1:0];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int N_IRQ   = 13,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wen,
  input logic [4:0]         cfg_addr,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic [DATA_W-1:0]  cfg_rdata,
  input logic [N_LINES-1:0] pin_oe,
  input logic [N_IRQ-1:0]   irq_out,
  input logic [N_LINES-1:0] hit,
  input logic [N_LINES-1:0] pend
);
  logic mapped;
  assign mapped = (cfg_addr == 5'h00) || (cfg_addr == 5'h04) || (cfg_addr == 5'h08) ||
                  (cfg_addr == 5'h0C) || (cfg_addr == 5'h10) || (cfg_addr == 5'h14);

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wen && cfg_addr == A_DIR) |=> (pin_oe == ~$past(cfg_wdata[N_LINES-1:0]))); // R2

  AST_EVENT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(hit)) == '0)); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wen && cfg_addr == A_EVENT) |=>
      ((pend & $past(cfg_wdata[N_LINES-1:0]) & ~$past(hit)) == '0)); // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((pend & $past(hit)) == $past(hit))); // R9

  AST_IRQ_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == A_EVENT) |-> (cfg_rdata[N_IRQ-1:0] == irq_out)); // R10

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (cfg_rdata == '0)); // R12
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_LINES(N_LINES), .N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_oe(pin_oe),
  .irq_out(irq_out), .hit(hit_vec), .pend(pend_vec)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wen = 1'b0;
  logic [4:0]  cfg_addr = 5'h00;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic [12:0] irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // behavioural reference model
  logic [15:0] m_s1, m_s2, m_s3, m_ev, m_drive, m_dir;
  int m_sty [16];

  function automatic bit m_hit(int s, bit c, bit l);
    case (s)
      0: return c;
      1: return !c;
      2: return c && !l;
      3: return !c && l;
      4: return c != l;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_ev = '0;
      m_drive = '0; m_dir = 16'hFFFF;
      for (int i = 0; i < 16; i++) m_sty[i] = 0;
    end else begin
      logic [15:0] nev;
      for (int i = 0; i < 16; i++) begin
        bit clr;
        clr = cfg_wen && cfg_addr == 5'h0C && cfg_wdata[i];
        nev[i] = m_hit(m_sty[i], m_s2[i], m_s3[i]) || (m_ev[i] && !clr);
      end
      m_ev = nev;
      if (cfg_wen) begin
        if (cfg_addr == 5'h00) m_drive = cfg_wdata[15:0];
        if (cfg_addr == 5'h04) m_dir = cfg_wdata[15:0];
        for (int i = 0; i < 16; i++) begin
          if ((i < 8 && cfg_addr == 5'h10) || (i >= 8 && cfg_addr == 5'h14))
            m_sty[i] = int'((cfg_wdata >> (3 * (i % 8))) & 32'd7);
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  function automatic logic [31:0] m_read(logic [4:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      5'h00: v = {16'h0, m_drive};
      5'h04: v = {16'h0, m_dir};
      5'h08: v = {16'h0, m_s2};
      5'h0C: v = {16'h0, m_ev};
      5'h10: for (int i = 0; i < 8; i++) v = v | (32'(m_sty[i]) << (3 * i));
      5'h14: for (int i = 0; i < 8; i++) v = v | (32'(m_sty[i + 8]) << (3 * i));
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string tag;
    logic [31:0] e;
    e = m_read(cfg_addr);
    case (cfg_addr)
      5'h00, 5'h04: tag = "R2 read";
      5'h08:        tag = "R3 read";
      5'h0C:        tag = "R8 read";
      5'h10, 5'h14: tag = "R4 read";
      default:      tag = "R12 read";
    endcase
    chk(cfg_rdata == e, tag, cfg_rdata, e);
    chk(pin_out == m_drive, "R2 pin_out", 32'(pin_out), 32'(m_drive));
    chk(pin_oe == ~m_dir, "R2 pin_oe", 32'(pin_oe), 32'(~m_dir));
    chk(irq_out == m_ev[12:0], "R10 irq_out", 32'(irq_out), 32'(m_ev[12:0]));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    cfg_wen = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wen = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] mask, logic [31:0] exp, string tag);
    cfg_addr = a;
    #1;
    chk((cfg_rdata & mask) == exp, tag, cfg_rdata & mask, exp);
  endtask

  function automatic logic [31:0] fill(int code);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) v = v | (32'(code) << (3 * i));
    return v;
  endfunction

  initial begin
    logic [31:0] v;
    logic [15:0] lf;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(5'h04, 32'hFFFF_FFFF, 32'h0000_FFFF, "R1 direction");
    rd(5'h00, 32'hFFFF_FFFF, 32'h0, "R1 output word");
    rd(5'h10, 32'hFFFF_FFFF, 32'h0, "R1 style word");
    rd(5'h0C, 32'hFFFF_FFFF, 32'h0, "R1 events");
    chk(pin_oe == 16'h0 && irq_out == 13'h0, "R1 pins", {pin_oe, 3'b0, irq_out}, 32'h0);

    // R2 direction and output data
    wr(5'h00, 32'h0000_A5C3);
    wr(5'h04, 32'h0000_0F0F);
    chk(pin_out == 16'hA5C3, "R2 pin_out", 32'(pin_out), 32'hA5C3);
    chk(pin_oe == 16'hF0F0, "R2 pin_oe", 32'(pin_oe), 32'hF0F0);

    // R4 all lines rising, then line 3 timing (R3, R11)
    wr(5'h10, fill(2));
    wr(5'h14, fill(2));
    rd(5'h14, 32'hFFFF_FFFF, 32'h0049_2492, "R4 style layout");
    wr(5'h0C, 32'hFFFF);
    pin_in = 16'h0008;
    tick(); tick();
    rd(5'h08, 32'hFFFF, 32'h0008, "R3 level after two edges");
    rd(5'h0C, 32'hFFFF, 32'h0000, "R11 not yet set");
    tick();
    rd(5'h0C, 32'hFFFF, 32'h0008, "R11 set on third edge");
    chk(irq_out == 13'h0008, "R11 irq", 32'(irq_out), 32'h8);

    // R8 write-one-to-clear
    wr(5'h0C, 32'h0);
    rd(5'h0C, 32'hFFFF, 32'h0008, "R8 zero write keeps");
    wr(5'h0C, 32'h8);
    rd(5'h0C, 32'hFFFF, 32'h0000, "R8 one write clears");

    // R6 falling and any-transition on line 3
    v = fill(2); v[11:9] = 3'd3;
    wr(5'h10, v);
    pin_in = 16'h0000;
    tick(); tick(); tick();
    rd(5'h0C, 32'h8, 32'h8, "R6 falling");
    v[11:9] = 3'd4;
    wr(5'h10, v);
    wr(5'h0C, 32'hFFFF);
    pin_in = 16'h0008;
    tick(); tick(); tick();
    rd(5'h0C, 32'h8, 32'h8, "R6 any rise");
    wr(5'h0C, 32'h8);
    pin_in = 16'h0000;
    tick(); tick(); tick();
    rd(5'h0C, 32'h8, 32'h8, "R6 any fall");

    // R5 level high on line 13, R10 no irq for it
    v = fill(2); v[17:15] = 3'd0;
    wr(5'h14, v);
    wr(5'h0C, 32'hFFFF);
    pin_in = 16'h2000;
    tick(); tick(); tick();
    rd(5'h0C, 32'hFFFF, 32'h2000, "R5 level high");
    chk(irq_out == 13'h0, "R10 line 13 no irq", 32'(irq_out), 32'h0);
    wr(5'h0C, 32'h2000);
    rd(5'h0C, 32'h2000, 32'h2000, "R5 clear while held");
    pin_in = 16'h0000;
    tick(); tick(); tick();
    wr(5'h0C, 32'h2000);
    rd(5'h0C, 32'h2000, 32'h0000, "R5 clear after release");
    // R5 level low on line 8
    v[2:0] = 3'd1;
    wr(5'h14, v);
    tick();
    rd(5'h0C, 32'h0100, 32'h0100, "R5 level low");

    // R7 reserved codes on lines 0..2
    v = fill(2); v[2:0] = 3'd5; v[5:3] = 3'd6; v[8:6] = 3'd7;
    wr(5'h10, v);
    wr(5'h0C, 32'hFFFF);
    for (int k = 0; k < 6; k++) begin
      pin_in[2:0] = ~pin_in[2:0];
      tick(); tick();
    end
    rd(5'h0C, 32'h7, 32'h0, "R7 reserved codes");

    // R9 event and clear on the same edge, line 2 rising
    v[8:6] = 3'd2;
    wr(5'h10, v);
    pin_in[2] = 1'b0;
    tick(); tick(); tick();
    wr(5'h0C, 32'h4);
    pin_in[2] = 1'b1;
    tick(); tick();
    cfg_wen = 1'b1; cfg_addr = 5'h0C; cfg_wdata = 32'h4;
    tick();
    cfg_wen = 1'b0;
    rd(5'h0C, 32'h4, 32'h4, "R9 set wins");

    // R12 holes and unused bits
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h18, 32'hFFFF_FFFF, 32'h0, "R12 hole 0x18");
    rd(5'h1C, 32'hFFFF_FFFF, 32'h0, "R12 hole 0x1C");
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, 32'hFFFF_FFFF, 32'h0000_FFFF, "R12 upper bits");
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, 32'hFF00_0000, 32'h0, "R4 upper style bits");

    // mixed traffic against the model
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (n % 3 == 0) pin_in = pin_in ^ lf;
      if (n % 7 == 0) begin
        cfg_wen = 1'b1;
        case (lf[2:0])
          3'd0: cfg_addr = 5'h10;
          3'd1: cfg_addr = 5'h14;
          3'd2: cfg_addr = 5'h04;
          3'd3: cfg_addr = 5'h00;
          3'd4: cfg_addr = 5'h18;
          default: cfg_addr = 5'h0C;
        endcase
        cfg_wdata = {lf, ~lf};
      end else begin
        cfg_wen = 1'b0;
        cfg_addr = {lf[4:2], 2'b00};
      end
      tick();
    end
    cfg_wen = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule